// File: doc/BRIEF.md
# Shared-Source Noise Fan-Out

This block produces a set of real white-noise streams for a multipath fading generator. There is one I stream and one Q stream for each complex path. The default is 24 outputs for 12 paths. A single approximate Gaussian source feeds all of them, in place of one generator per stream. The source delivers one fresh sample on every enabled clock. A rotating slot counter routes that sample into exactly one output register. A one-clock strobe flags each register when it is refreshed.

The counter has one more slot than there are outputs: 25 slots for 24 outputs. With a 10 MHz sample clock, this gives an even 400 kHz refresh rate on every output. That rate is far above the few-kHz rate at which the downstream path coefficients are produced. The extra slot loads nothing, and its sample is dropped.

The source adds twelve uniform 16-bit words, each from its own maximal-length LFSR. It then subtracts the mean of the sum. The result is a signed sample scaled so that 65536 represents one standard deviation. An enable input freezes the whole block.

Top module: `noise_fanout_top`

## Requirements
- R1: After a synchronous reset, every output register reads zero, every strobe is low, and the first enabled clock loads output 0.
- R2: On an enabled clock where the slot is k, with k from 0 to 23, output k takes the value that `sample_o` showed before that edge. Strobe bit k is high for exactly the following cycle, and no other output changes. Output k occupies bits [21k+20 : 21k] of `noise_o`.
- R3: On an enabled clock where the slot is 24, no output changes and no strobe is raised.
- R4: The slot advances by one on each enabled clock and wraps from 24 to 0. Each output is therefore refreshed exactly once every 25 enabled clocks.
- R5: At most one strobe bit is high in any cycle.
- R6: While `en_i` is low, the slot counter and the LFSRs hold. As a result, `sample_o` is stable, no strobe is raised and no output changes.
- R7: `sample_o` is a 21-bit two's-complement value equal to the sum of twelve unsigned 16-bit words minus 393216. It always lies in [-393216, 393204].
- R8: Over 4000 consecutive enabled samples, the mean magnitude is below 0.1 and the variance lies between 0.75 and 1.25, in units of 65536.
- R9: The source advances on every enabled clock. At least 95% of consecutive enabled samples differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance enable; low freezes the block |
| sample_o | output | 21 | Current source sample, signed, 16 fractional bits |
| noise_o | output | 504 | 24 output registers of 21 bits, output k at bits 21k upward |
| valid_o | output | 24 | Per-output refresh strobe, one clock wide |

## Verification
A slot counter that skips, repeats or fails to wrap shows up at the ports on the very next enabled clock. The strobe appears on the wrong bit, or appears on the idle slot, and the register that changes no longer matches the sample shown before the edge. A counter or LFSR that moves while the block is disabled is visible as soon as the block is disabled: `sample_o` changes, or the next strobe lands one position off. A wrong mean offset, a stuck LFSR or duplicated seeds only shows over thousands of samples, as a shifted mean, a wrong variance or repeated values.

// File: rtl/noise_fanout_pkg.sv
package noise_fanout_pkg;

   // Galois right-shift feedback masks for maximal-length sequences.
   function automatic logic [63:0] nf_lfsr_mask(input int width);
      case (width)
         8:       return 64'h0000_0000_0000_00B8;
         16:      return 64'h0000_0000_0000_B400;
         24:      return 64'h0000_0000_00E1_0000;
         32:      return 64'h0000_0000_8020_0003;
         default: return 64'h0;
      endcase
   endfunction

   function automatic bit nf_width_ok(input int width);
      return (width == 8) || (width == 16) || (width == 24) || (width == 32);
   endfunction

   // Distinct nonzero seeds: (idx+1) times an odd constant, modulo 2^width.
   function automatic logic [63:0] nf_seed(input int idx, input int width);
      logic [63:0] prod;
      logic [63:0] mask;
      prod = (64'(idx) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
      mask = (width >= 64) ? '1 : ((64'd1 << width) - 64'd1);
      return prod & mask;
   endfunction

endpackage

// File: rtl/nf_lfsr.sv
module nf_lfsr #(
   parameter int           WIDTH = 16,
   parameter logic [63:0]  SEED  = 64'h1,
   parameter logic [63:0]  MASK  = 64'hB400
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             en_i,
   output logic [WIDTH-1:0] word_o
);
   localparam logic [WIDTH-1:0] SEED_W = WIDTH'(SEED);
   localparam logic [WIDTH-1:0] MASK_W = WIDTH'(MASK);

   logic [WIDTH-1:0] state_q;
   logic [WIDTH-1:0] next_s;

   // Advance WIDTH bit-steps per clock so successive words share no bits.
   always_comb begin
      next_s = state_q;
      for (int b = 0; b < WIDTH; b++) begin
         next_s = next_s[0] ? ((next_s >> 1) ^ MASK_W) : (next_s >> 1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     state_q <= SEED_W;
      else if (en_i) state_q <= next_s;
   end

   assign word_o = state_q;
endmodule

// File: rtl/nf_gauss_src.sv
module nf_gauss_src
   import noise_fanout_pkg::*;
#(
   parameter int NUM_LFSR = 12,
   parameter int LFSR_W   = 16,
   parameter int SAMPLE_W = LFSR_W + $clog2(NUM_LFSR + 1) + 1
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic                en_i,
   output logic [SAMPLE_W-1:0] sample_o
);
   localparam int SUM_W = SAMPLE_W - 1;
   localparam logic [63:0] MEAN64 = 64'(NUM_LFSR) << (LFSR_W - 1);
   localparam logic [SAMPLE_W-1:0] MEAN_V = SAMPLE_W'(MEAN64);

   logic [LFSR_W-1:0] words [NUM_LFSR];
   logic [SUM_W-1:0]  sum_c;

   for (genvar i = 0; i < NUM_LFSR; i++) begin : g_lfsr
      nf_lfsr #(
         .WIDTH (LFSR_W),
         .SEED  (nf_seed(i, LFSR_W)),
         .MASK  (nf_lfsr_mask(LFSR_W))
      ) u_lfsr (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .en_i   (en_i),
         .word_o (words[i])
      );
   end

   always_comb begin
      sum_c = '0;
      for (int i = 0; i < NUM_LFSR; i++) begin
         sum_c = sum_c + SUM_W'(words[i]);
      end
   end

   assign sample_o = {1'b0, sum_c} - MEAN_V;
endmodule

// File: rtl/nf_slot_ctr.sv
module nf_slot_ctr #(
   parameter int NUM_SLOTS = 25,
   parameter int NUM_OUT   = 24,
   parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   output logic [SLOT_W-1:0] slot_o,
   output logic              load_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;
   logic              in_range;

   // Counter variant: free wrap for a power-of-two slot count, compare otherwise.
   if ((1 << SLOT_W) == NUM_SLOTS) begin : g_pow2
      always_ff @(posedge clk_i) begin
         if (rst_i)     slot_q <= '0;
         else if (en_i) slot_q <= slot_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk_i) begin
         if (rst_i)     slot_q <= '0;
         else if (en_i) slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      end
   end

   // Idle-slot variant: only present when there are more slots than outputs.
   if (NUM_SLOTS == NUM_OUT) begin : g_no_idle
      assign in_range = 1'b1;
   end else begin : g_idle
      assign in_range = ({1'b0, slot_q} < (SLOT_W + 1)'(NUM_OUT));
   end

   assign slot_o = slot_q;
   assign load_o = en_i & in_range;
endmodule

// File: rtl/nf_out_bank.sv
module nf_out_bank #(
   parameter int NUM_OUT  = 24,
   parameter int SAMPLE_W = 21,
   parameter int SLOT_W   = 5
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        load_i,
   input  logic [SLOT_W-1:0]           slot_i,
   input  logic [SAMPLE_W-1:0]         sample_i,
   output logic [NUM_OUT*SAMPLE_W-1:0] noise_o,
   output logic [NUM_OUT-1:0]          valid_o
);
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
      logic              hit;
      logic [SAMPLE_W-1:0] reg_q;
      logic              vld_q;

      assign hit = load_i && ({1'b0, slot_i} == (SLOT_W + 1)'(k));

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            reg_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= hit;
            if (hit) reg_q <= sample_i;
         end
      end

      assign noise_o[k*SAMPLE_W +: SAMPLE_W] = reg_q;
      assign valid_o[k] = vld_q;
   end
endmodule

// File: rtl/noise_fanout_top.sv
module noise_fanout_top
   import noise_fanout_pkg::*;
#(
   parameter int NUM_OUT   = 24,
   parameter int NUM_SLOTS = 25,
   parameter int NUM_LFSR  = 12,
   parameter int LFSR_W    = 16,
   parameter int SAMPLE_W  = LFSR_W + $clog2(NUM_LFSR + 1) + 1
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic                        en_i,
   output logic [SAMPLE_W-1:0]         sample_o,
   output logic [NUM_OUT*SAMPLE_W-1:0] noise_o,
   output logic [NUM_OUT-1:0]          valid_o
);
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   if (NUM_OUT < 1)
      $error("noise_fanout_top: NUM_OUT must be at least 1");
   if (NUM_SLOTS < NUM_OUT)
      $error("noise_fanout_top: NUM_SLOTS must cover every output");
   if (NUM_SLOTS < 2)
      $error("noise_fanout_top: NUM_SLOTS must be at least 2");
   if (!nf_width_ok(LFSR_W))
      $error("noise_fanout_top: LFSR_W has no feedback mask");
   if (NUM_LFSR < 1 || NUM_LFSR >= (1 << 8))
      $error("noise_fanout_top: NUM_LFSR out of range");
   if (SAMPLE_W < LFSR_W + $clog2(NUM_LFSR + 1) + 1)
      $error("noise_fanout_top: SAMPLE_W too narrow for the sum");

   logic [SLOT_W-1:0] slot;
   logic              load;

   nf_gauss_src #(
      .NUM_LFSR (NUM_LFSR),
      .LFSR_W   (LFSR_W),
      .SAMPLE_W (SAMPLE_W)
   ) u_src (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .sample_o (sample_o)
   );

   nf_slot_ctr #(
      .NUM_SLOTS (NUM_SLOTS),
      .NUM_OUT   (NUM_OUT),
      .SLOT_W    (SLOT_W)
   ) u_ctr (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .slot_o (slot),
      .load_o (load)
   );

   nf_out_bank #(
      .NUM_OUT  (NUM_OUT),
      .SAMPLE_W (SAMPLE_W),
      .SLOT_W   (SLOT_W)
   ) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (load),
      .slot_i   (slot),
      .sample_i (sample_o),
      .noise_o  (noise_o),
      .valid_o  (valid_o)
   );
endmodule

// File: rtl/nf_checker.sv
module nf_checker #(
   parameter int NUM_OUT   = 24,
   parameter int NUM_SLOTS = 25,
   parameter int NUM_LFSR  = 12,
   parameter int LFSR_W    = 16,
   parameter int SAMPLE_W  = 21
) (
   input logic                        clk_i,
   input logic                        rst_i,
   input logic                        en_i,
   input logic [SAMPLE_W-1:0]         sample_o,
   input logic [NUM_OUT*SAMPLE_W-1:0] noise_o,
   input logic [NUM_OUT-1:0]          valid_o
);
   localparam int   GAP_W = $clog2(NUM_SLOTS + 2) + 1;
   localparam longint MEAN  = longint'(NUM_LFSR) <<< (LFSR_W - 1);
   localparam longint S_MIN = -MEAN;
   localparam longint S_MAX = MEAN - longint'(NUM_LFSR);

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   // Enabled clocks since output 0 was last refreshed.
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (valid_o[0]) begin
            gap_q  <= en_i ? GAP_W'(1) : '0;
            seen_q <= 1'b1;
         end else if (en_i) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(valid_o));

   assert_hold_strobe_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (valid_o == '0));

   assert_hold_sample_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(sample_o));

   assert_idle_slot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o[NUM_OUT-1] && en_i) |=> (valid_o == '0) && $stable(noise_o));

   assert_refresh_period_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o[0] && seen_q && $past(!rst_i)) |-> (gap_q == GAP_W'(NUM_SLOTS)));

   assert_sample_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (longint'($signed(sample_o)) >= S_MIN) && (longint'($signed(sample_o)) <= S_MAX));

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
      assert_load_value_R2: assert property (@(posedge clk_i) disable iff (rst_i)
         valid_o[k] |-> (noise_o[k*SAMPLE_W +: SAMPLE_W] == $past(sample_o)));
      if (k < NUM_OUT - 1) begin : g_ord
         assert_slot_order_R2: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_o[k] && en_i) |=> valid_o[k+1]);
      end
   end
endmodule

bind noise_fanout_top nf_checker #(
   .NUM_OUT   (NUM_OUT),
   .NUM_SLOTS (NUM_SLOTS),
   .NUM_LFSR  (NUM_LFSR),
   .LFSR_W    (LFSR_W),
   .SAMPLE_W  (SAMPLE_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .en_i     (en_i),
   .sample_o (sample_o),
   .noise_o  (noise_o),
   .valid_o  (valid_o)
);

// File: tb/noise_fanout_top_tb.sv
`timescale 1ns/1ps
module noise_fanout_top_tb;
   localparam int NO = 24;
   localparam int NS = 25;
   localparam int NL = 12;
   localparam int LW = 16;
   localparam int SW = 21;
   localparam longint MINV = -393216;
   localparam longint MAXV = 393204;
   localparam int NVEC = 12;
   // {en, expected slot before the edge}
   localparam logic [5:0] VEC [NVEC] = '{
      {1'b1, 5'd0}, {1'b1, 5'd1}, {1'b1, 5'd2}, {1'b0, 5'd3},
      {1'b0, 5'd3}, {1'b1, 5'd3}, {1'b1, 5'd4}, {1'b0, 5'd5},
      {1'b1, 5'd5}, {1'b1, 5'd6}, {1'b1, 5'd7}, {1'b1, 5'd8}
   };

   logic              clk = 1'b0;
   logic              rst_i;
   logic              en_i;
   logic [SW-1:0]     sample_o;
   logic [NO*SW-1:0]  noise_o;
   logic [NO-1:0]     valid_o;

   noise_fanout_top u_dut (
      .clk_i    (clk),
      .rst_i    (rst_i),
      .en_i     (en_i),
      .sample_o (sample_o),
      .noise_o  (noise_o),
      .valid_o  (valid_o)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int model_slot = 0;
   int n_changed = 0;
   int n_en_steps = 0;
   bit done = 1'b0;
   logic signed [SW-1:0] pre_s;
   logic [NO*SW-1:0]     pre_n;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int diffs(input logic [NO*SW-1:0] a, input logic [NO*SW-1:0] b);
      int n = 0;
      for (int k = 0; k < NO; k++)
         if (a[k*SW +: SW] != b[k*SW +: SW]) n++;
      return n;
   endfunction

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit e);
      logic [NO-1:0]    ev;
      logic [NO*SW-1:0] en_exp;
      en_i  = e;
      pre_s = sample_o;
      pre_n = noise_o;
      chk(longint'(pre_s) >= MINV && longint'(pre_s) <= MAXV, "R7 sample range",
          longint'(pre_s), MAXV);
      @(posedge clk);
      @(negedge clk);
      chk($countones(valid_o) <= 1, "R5 strobe count", $countones(valid_o), 1);
      if (e) begin
         n_en_steps++;
         if (sample_o != pre_s) n_changed++;
         if (model_slot < NO) begin
            ev = '0;
            ev[model_slot] = 1'b1;
            en_exp = pre_n;
            en_exp[model_slot*SW +: SW] = pre_s;
            chk(valid_o == ev, "R2 strobe position", longint'(valid_o), longint'(ev));
            chk(noise_o[model_slot*SW +: SW] == pre_s, "R2 loaded value",
                longint'($signed(noise_o[model_slot*SW +: SW])), longint'(pre_s));
            chk(noise_o == en_exp, "R2 other outputs unchanged", diffs(noise_o, en_exp), 0);
         end else begin
            chk(valid_o == '0, "R3 idle slot strobe", longint'(valid_o), 0);
            chk(noise_o == pre_n, "R3 idle slot outputs", diffs(noise_o, pre_n), 0);
         end
         model_slot = (model_slot + 1) % NS;
      end else begin
         chk(valid_o == '0, "R6 strobe while disabled", longint'(valid_o), 0);
         chk(noise_o == pre_n, "R6 outputs while disabled", diffs(noise_o, pre_n), 0);
         chk(sample_o == pre_s, "R6 sample held", longint'($signed(sample_o)), longint'(pre_s));
      end
   endtask

   initial begin
      int cnt;
      real x, sum, sumsq, mean, var_v;
      rst_i = 1'b1;
      en_i  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_i = 1'b0;
      // R1 reset state
      chk(noise_o == '0, "R1 outputs cleared", diffs(noise_o, '0), 0);
      chk(valid_o == '0, "R1 strobes low", longint'(valid_o), 0);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         chk(int'(VEC[i][4:0]) == model_slot, "R4 table slot", model_slot, int'(VEC[i][4:0]));
         step(VEC[i][5]);
         if (i == 0) chk(valid_o[0], "R1 first load is output 0", longint'(valid_o), 1);
      end

      // Through the idle slot and the wrap
      for (int i = 0; i < 30; i++) step(1'b1);
      chk(model_slot == 14, "R4 wrap position", model_slot, 14);

      // Refresh period: 100 enabled clocks give exactly 4 refreshes of output 7
      cnt = 0;
      for (int i = 0; i < 100; i++) begin
         step(1'b1);
         if (valid_o[7]) cnt++;
      end
      chk(cnt == 4, "R4 refresh count", cnt, 4);

      // Disabled stretch in the middle of a rotation
      for (int i = 0; i < 5; i++) step(1'b0);
      step(1'b1);

      // Reset in mid-run
      rst_i = 1'b1;
      en_i  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst_i = 1'b0;
      model_slot = 0;
      chk(noise_o == '0, "R1 outputs cleared after reset", diffs(noise_o, '0), 0);
      chk(valid_o == '0, "R1 strobes low after reset", longint'(valid_o), 0);
      step(1'b1);
      chk(valid_o[0], "R1 output 0 loads first after reset", longint'(valid_o), 1);

      // Statistics
      sum = 0.0;
      sumsq = 0.0;
      n_changed = 0;
      n_en_steps = 0;
      for (int i = 0; i < 4000; i++) begin
         step(1'b1);
         x = $itor(pre_s) / 65536.0;
         sum   += x;
         sumsq += x * x;
      end
      mean  = sum / 4000.0;
      var_v = sumsq / 4000.0 - mean * mean;
      chk(mean < 0.1 && mean > -0.1, "R8 mean x1000", longint'(mean * 1000.0), 0);
      chk(var_v > 0.75 && var_v < 1.25, "R8 variance x1000", longint'(var_v * 1000.0), 1000);
      chk(n_changed * 100 >= n_en_steps * 95, "R9 samples advancing", n_changed, n_en_steps);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule